// File: doc/BRIEF.md
# Transposed-Form Pipelined FIR Filter

This block is a fixed-coefficient, 32-tap finite impulse response filter for 16-bit signed samples. It uses the transposed direct form. Each new sample goes at the same time to every tap multiplier. Each product is added to a registered partial sum that moves one stage toward the output. The longest path through any stage is therefore one multiply followed by one add, however many taps the filter has.

A sample is accepted on every clock edge where the one-cycle input strobe is high. Cycles where the strobe is low leave the filter state unchanged, so samples may arrive at any rate up to one per clock. Products and partial sums are kept at full 32-bit precision. A single saturating quantizer turns the final sum back into a 16-bit result. That result is registered together with a one-cycle output strobe.

The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block, so the block accepts samples two clock edges after the release.

Top module: `fir_transposed`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid is 0, out_data is 0 and every partial-sum register is zero, so the first outputs after reset depend only on samples accepted after reset.
- R2: out_valid is 1 for exactly the one clock cycle that follows each edge where in_valid was 1, and 0 after every edge where in_valid was 0.
- R3: out_data changes only on an edge where a sample is accepted. Otherwise it holds its value.
- R4: For the n-th accepted sample x(n), the full-precision sum is S(n) = sum over k = 0..31 of h(k)·x(n−k). Here x(n−k) is the sample accepted k acceptances earlier, and it counts as 0 if it came before reset. out_data presents the quantized S(n) on the cycle that out_valid is 1.
- R5: The coefficients are h(k) = 192·(k+1) for k = 0..15 and h(k) = 192·(32−k) for k = 16..31, as signed 16-bit values. h(0) weights the newest sample.
- R6: Idle cycles between samples, of any number, do not shift or alter the partial sums. The output sequence depends only on the sequence of accepted samples.
- R7: When −2^30 ≤ S(n) < 2^30, out_data equals bits [30:15] of the 32-bit sum, which is floor(S(n) / 2^15) as a two's-complement value.
- R8: When S(n) ≥ 2^30, out_data is 32767 (0x7FFF). When S(n) < −2^30, out_data is −32768 (0x8000).
- R9: After reset, a single nonzero sample v followed by zeros produces the outputs floor(v·h(k) / 2^15) for k = 0, 1, 2, … in turn. The impulse response comes out in coefficient order with h(0) first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | One-cycle strobe: the sample on in_data is accepted on this edge |
| in_data | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result on out_data |
| out_data | output | 16 | Signed quantized and saturated filter output |

## Verification
Three behaviours are checked by assertions on every cycle: the output strobe follows each accepted sample by exactly one cycle, out_data holds between strobes, and reset clears the outputs. The arithmetic can only be shown by the bench's scenarios, which compare each output against a reference convolution. That covers the reversed coefficient order along the chain, the independence from idle gaps, floor quantization of negative sums, and saturation at both rails. Clearing of the partial sums by a mid-run reset is also shown only by a scenario, which applies the reset and then observes the next impulse response.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int unsigned TAPS      = 32;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned COEF_W    = 16;
  localparam int unsigned COEF_STEP = 192;

  // Symmetric triangular coefficient set, computed rather than tabulated.
  function automatic logic signed [COEF_W-1:0] tap_coef(input int unsigned k,
                                                         input int unsigned n,
                                                         input int unsigned step);
    int unsigned m;
    m = (k < n / 2) ? (k + 1) : (n - k);
    return COEF_W'(m * step);
  endfunction

endpackage

// File: rtl/fir_rst_sync.sv
module fir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned AW = DW + CW,
  parameter logic signed [CW-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_out
);

  logic signed [AW-1:0] prod;
  logic signed [AW-1:0] sum_nxt;
  logic signed [AW-1:0] sum_q;

  // One multiply and one add per stage.
  always_comb begin
    prod    = x * COEF;
    sum_nxt = sum_in + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= sum_nxt;
    end
  end

  assign sum_out = sum_q;

endmodule

// File: rtl/fir_quant.sv
module fir_quant #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = 15
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [DW-1:0] q
);

  localparam int unsigned HI_W = AW - FRAC - DW + 1;
  localparam logic signed [DW-1:0] Q_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] Q_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [HI_W-1:0] hi;
  logic            ovf;

  always_comb begin
    hi  = acc[AW-1 -: HI_W];
    ovf = !((&hi) || (~|hi));
    if (ovf) begin
      q = acc[AW-1] ? Q_MIN : Q_MAX;
    end else begin
      q = acc[FRAC +: DW];
    end
  end

endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
  parameter int unsigned NTAPS = fir_pkg::TAPS,
  parameter int unsigned DW    = fir_pkg::SAMPLE_W,
  parameter int unsigned CW    = fir_pkg::COEF_W,
  parameter int unsigned STEP  = fir_pkg::COEF_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int unsigned AW   = DW + CW;
  localparam int unsigned FRAC = CW - 1;
  localparam logic signed [CW-1:0] H0 = fir_pkg::tap_coef(0, NTAPS, STEP);

  logic                 rst_sync_n;
  logic signed [DW-1:0] x;
  logic signed [AW-1:0] part [1:NTAPS];
  logic signed [AW-1:0] head_prod;
  logic signed [AW-1:0] head_sum;
  logic signed [DW-1:0] q;
  logic                 valid_nxt;
  logic [DW-1:0]        data_nxt;
  logic                 valid_q;
  logic [DW-1:0]        data_q;

  fir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign x           = in_data;
  assign part[NTAPS] = '0;

  // Tap k is fed by tap k+1; the far end carries h(NTAPS-1).
  for (genvar k = 1; k < NTAPS; k++) begin : g_tap
    fir_tap #(
      .DW   (DW),
      .CW   (CW),
      .AW   (AW),
      .COEF (fir_pkg::tap_coef(k, NTAPS, STEP))
    ) u_tap (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en      (in_valid),
      .x       (x),
      .sum_in  (part[k+1]),
      .sum_out (part[k])
    );
  end

  always_comb begin
    head_prod = x * H0;
    head_sum  = part[1] + head_prod;
  end

  fir_quant #(
    .AW   (AW),
    .DW   (DW),
    .FRAC (FRAC)
  ) u_quant (
    .acc (head_sum),
    .q   (q)
  );

  always_comb begin
    valid_nxt = in_valid;
    data_nxt  = in_valid ? q : data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_nxt;
      data_q  <= data_nxt;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  // R2: a strobe is followed by exactly one output strobe
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: no strobe in, no strobe out
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: output holds between accepted samples
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

endmodule

bind fir_transposed fir_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_fir_transposed.sv
module sim_fir_transposed;

  localparam int N = 32;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  int checks;
  int errors;
  bit done;
  longint hist [0:N-1];

  fir_transposed u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic longint coef(input int k);
    return (k < 16) ? 192 * (k + 1) : 192 * (32 - k);
  endfunction

  function automatic int quantize(input longint s);
    if (s >= (64'sd1 <<< 30)) return 32767;
    if (s < -(64'sd1 <<< 30)) return -32768;
    return int'(s >>> 15);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < N; i++) hist[i] = 0;
  endtask

  // Drive one sample, check the strobe and result, then idle and check holds.
  task automatic send(input int v, input int gap, input string req);
    longint s;
    int exp;
    in_valid = 1'b1;
    in_data  = 16'(v);
    for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    s = 0;
    for (int k = 0; k < N; k++) s += coef(k) * hist[k];
    exp = quantize(s);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 16'($urandom);
    check("R2", int'(out_valid), 1);
    check(req, int'($signed(out_data)), exp);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R2", int'(out_valid), 0);
      check("R3", int'($signed(out_data)), exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    clear_hist();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    clear_hist();
    @(negedge clk);
    do_reset();

    // R9/R5: impulse response appears in coefficient order, h(0) first.
    send(32767, 0, "R9");
    for (int i = 0; i < N + 3; i++) send(0, 0, "R9");

    // R7: small negative sum rounds toward minus infinity.
    send(-1, 1, "R7");
    for (int i = 0; i < 5; i++) send(0, 0, "R7");

    // R8: both saturation rails.
    for (int i = 0; i < N + 2; i++) send(32767, 0, "R8");
    for (int i = 0; i < N + 2; i++) send(-32768, 0, "R8");

    // R1: mid-run reset clears partial sums; next impulse is clean.
    for (int i = 0; i < 5; i++) send(int'($urandom_range(0, 20000)), 0, "R4");
    do_reset();
    send(1000, 0, "R1");
    for (int i = 0; i < 4; i++) send(0, 0, "R1");

    // R4/R6: random samples with random idle gaps.
    for (int i = 0; i < 400; i++) begin
      send(int'($signed(16'($urandom))), int'($urandom_range(0, 3)), "R6");
    end
    for (int i = 0; i < 200; i++) begin
      send(int'($signed(16'($urandom))), 0, "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule